// File: doc/BRIEF.md
# If-Then Predication State Unit

This block holds the predication state that decides whether each of up to four instructions after an if-then instruction does any work. When the if-then instruction issues, its then/else pattern is merged with the selected condition result and loaded into a small shift register. Every later instruction that issues shifts the leading bit out and a one in at the far end. A leading zero suppresses that instruction. A state of all ones means no predication is in force.

The current state is always visible on an output port. Exception entry logic can save it from there, and exception return writes it back through the restore port. An instruction resumed in the middle of a predicated group then sees only the bits that remained. Breakpoint-class instructions are flagged as exempt: they always execute and leave the state alone. Condition evaluation, decode and exception sequencing live outside this block.

Top module: `pred_state_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes all ones (4'b1111) on that edge.
- R2: A load sets state bit `3-k` to `~(load_pat[3-k] ^ load_cond)` for every position k from 0 up to `load_len`. Position 0 is the MSB and belongs to the first instruction after the if-then. `load_len` holds the number of covered instructions minus one.
- R3: On a load, every state position k greater than `load_len` is set to 1.
- R4: An issue with `issue_exempt` low and no load or restore in the same cycle shifts the state left by one position on the clock edge, with a 1 entering at bit 0.
- R5: `exec_en` is high in a cycle with `issue_en` high and state bit 3 equal to 1. It is low when `issue_en` is high, `issue_exempt` is low and state bit 3 is 0. It is always low when `issue_en` is low.
- R6: An issue with `issue_exempt` high drives `exec_en` high whatever the state, and leaves the state unchanged.
- R7: `state_o` shows the current state in every cycle. A restore writes `restore_val` into the state on the clock edge, and the following issues are predicated by the restored bits.
- R8: A restore takes priority over a load and over a shift in the same cycle.
- R9: A load in the same cycle as a non-exempt issue wins over the shift. The issuing instruction's `exec_en` comes from the state held before the load.
- R10: With the state all ones, every issue executes and the state stays all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | If-then instruction loads the state |
| load_pat | input | 4 | Then/else pattern, MSB for first instruction |
| load_len | input | 2 | Covered instruction count minus one |
| load_cond | input | 1 | Selected condition result |
| issue_en | input | 1 | An instruction issues this cycle |
| issue_exempt | input | 1 | Issuing instruction is breakpoint-class |
| restore_en | input | 1 | Exception return writes the state |
| restore_val | input | 4 | Saved state to write back |
| exec_en | output | 1 | Issuing instruction performs its work |
| state_o | output | 4 | Current predication state |

## Verification
Exception return can fall in the same cycle as an issuing instruction, and also in the same cycle as an if-then load. In both cases the restore must win. The bench saves `state_o` partway through a group, loads a new pattern to act as the handler, and then pulses restore together with an issue. It expects the saved bits back in the state and judges `exec_en` against the state present before the edge. A load that coincides with a restore, and a load that coincides with an issue, are provoked the same way and checked against the priority order.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int PRED_W = 4;

  function automatic logic [PRED_W-1:0] all_ones();
    return '1;
  endfunction
endpackage

// File: rtl/pred_load_fmt.sv
module pred_load_fmt #(
  parameter int W     = pred_pkg::PRED_W,
  parameter int LEN_W = $clog2(W)
) (
  input  logic [W-1:0]     pat,
  input  logic [LEN_W-1:0] len,
  input  logic             cond,
  output logic [W-1:0]     val
);
  for (genvar k = 0; k < W; k++) begin : g_pos
    localparam int B = W - 1 - k;
    assign val[B] = (LEN_W'(k) <= len) ? ~(pat[B] ^ cond) : 1'b1;
  end
endmodule

// File: rtl/pred_shift_step.sv
module pred_shift_step #(
  parameter int W = pred_pkg::PRED_W
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         lead
);
  assign lead = cur[W-1];
  assign nxt  = {cur[W-2:0], 1'b1};
endmodule

// File: rtl/pred_state_unit.sv
module pred_state_unit #(
  parameter int W     = pred_pkg::PRED_W,
  parameter int LEN_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [W-1:0]     load_pat,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_cond,
  input  logic             issue_en,
  input  logic             issue_exempt,
  input  logic             restore_en,
  input  logic [W-1:0]     restore_val,
  output logic             exec_en,
  output logic [W-1:0]     state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] ld_val;
  logic [W-1:0] sh_val;
  logic         lead;
  logic         do_shift;

  pred_load_fmt #(.W(W), .LEN_W(LEN_W)) u_fmt (
    .pat (load_pat),
    .len (load_len),
    .cond(load_cond),
    .val (ld_val)
  );

  pred_shift_step #(.W(W)) u_shift (
    .cur (state_q),
    .nxt (sh_val),
    .lead(lead)
  );

  assign do_shift = issue_en & ~issue_exempt;

  always_ff @(posedge clk) begin
    if (rst)             state_q <= pred_pkg::all_ones();
    else if (restore_en) state_q <= restore_val;
    else if (load_en)    state_q <= ld_val;
    else if (do_shift)   state_q <= sh_val;
  end

  assign exec_en = issue_en & (issue_exempt | lead);
  assign state_o = state_q;
endmodule

// File: rtl/pred_state_chk.sv
module pred_state_chk #(
  parameter int W     = pred_pkg::PRED_W,
  parameter int LEN_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             issue_en,
  input logic             issue_exempt,
  input logic             restore_en,
  input logic [W-1:0]     restore_val,
  input logic             exec_en,
  input logic [W-1:0]     state_o
);
  p_reset_ones_r1: assert property (@(posedge clk) rst |=> state_o == '1);

  p_shift_in_one_r4: assert property (@(posedge clk) disable iff (rst)
    (issue_en && !issue_exempt && !load_en && !restore_en)
      |=> state_o == {$past(state_o[W-2:0]), 1'b1});

  p_exempt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_en && issue_exempt && !load_en && !restore_en) |=> $stable(state_o));

  p_exempt_runs_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_en && issue_exempt) |-> exec_en);

  p_suppress_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_en && !issue_exempt && !state_o[W-1]) |-> !exec_en);

  p_no_issue_r5: assert property (@(posedge clk) disable iff (rst)
    !issue_en |-> !exec_en);

  p_restore_wins_r8: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> state_o == $past(restore_val));

  p_ones_stay_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o == '1 && issue_en && !load_en && !restore_en)
      |-> exec_en ##1 state_o == '1);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!issue_en && !load_en && !restore_en) |=> $stable(state_o));
endmodule

bind pred_state_unit pred_state_chk #(.W(W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_en     (load_en),
  .issue_en    (issue_en),
  .issue_exempt(issue_exempt),
  .restore_en  (restore_en),
  .restore_val (restore_val),
  .exec_en     (exec_en),
  .state_o     (state_o)
);

// File: tb/tb_pred_state_unit.sv
module tb_pred_state_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] load_pat = '0;
  logic [1:0] load_len = '0;
  logic       load_cond = 1'b0;
  logic       issue_en = 1'b0;
  logic       issue_exempt = 1'b0;
  logic       restore_en = 1'b0;
  logic [3:0] restore_val = '0;
  logic       exec_en;
  logic [3:0] state_o;

  always #(CLK_P/2) clk = ~clk;

  pred_state_unit dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_pat(load_pat),
    .load_len(load_len), .load_cond(load_cond), .issue_en(issue_en),
    .issue_exempt(issue_exempt), .restore_en(restore_en),
    .restore_val(restore_val), .exec_en(exec_en), .state_o(state_o)
  );

  typedef struct {
    logic       ex;
    logic [3:0] st;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         total = 0;
  int         bad = 0;
  logic [3:0] m_state = 4'b1111;
  logic [3:0] saved;

  task automatic step(input logic r, input logic ld, input logic [3:0] pat,
                      input logic [1:0] len, input logic cond,
                      input logic iss, input logic exm,
                      input logic rs, input logic [3:0] rv, input string tag);
    item_t      it;
    logic [3:0] lv;
    @(negedge clk);
    rst = r; load_en = ld; load_pat = pat; load_len = len; load_cond = cond;
    issue_en = iss; issue_exempt = exm; restore_en = rs; restore_val = rv;
    for (int k = 0; k < 4; k++)
      lv[3-k] = (k <= int'(len)) ? ~(pat[3-k] ^ cond) : 1'b1;
    it.ex  = iss & (exm | m_state[3]);
    it.tag = tag;
    if (r)              m_state = 4'b1111;
    else if (rs)        m_state = rv;
    else if (ld)        m_state = lv;
    else if (iss && !exm) m_state = {m_state[2:0], 1'b1};
    it.st = m_state;
    sb.push_back(it);
  endtask

  task automatic do_load(input logic [3:0] pat, input logic [1:0] len,
                         input logic cond, input string tag);
    step(1'b0, 1'b1, pat, len, cond, 1'b0, 1'b0, 1'b0, 4'h0, tag);
  endtask

  task automatic do_issue(input logic exm, input string tag);
    step(1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b1, exm, 1'b0, 4'h0, tag);
  endtask

  initial begin : monitor
    item_t it;
    logic  ex;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        ex = exec_en;
        @(posedge clk);
        #(CLK_P/4);
        total += 2;
        if (ex !== it.ex) begin
          bad++;
          $display("FAIL %s exec_en actual=%b expected=%b", it.tag, ex, it.ex);
        end
        if (state_o !== it.st) begin
          bad++;
          $display("FAIL %s state_o actual=%b expected=%b", it.tag, state_o, it.st);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P*20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    step(1'b1, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R1");
    step(1'b1, 1'b1, 4'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R1");
    do_load(4'b1100, 2'd2, 1'b1, "R2");
    do_issue(1'b0, "R4");
    do_issue(1'b0, "R5");
    do_issue(1'b0, "R5");
    do_issue(1'b0, "R10");
    do_issue(1'b0, "R10");
    do_load(4'b1100, 2'd2, 1'b0, "R3");
    do_issue(1'b0, "R5");
    do_issue(1'b1, "R6");
    do_issue(1'b0, "R4");
    do_load(4'b1010, 2'd3, 1'b1, "R2");
    do_issue(1'b0, "R7");
    @(posedge clk);
    #(CLK_P/4);
    saved = state_o;
    do_load(4'b0000, 2'd0, 1'b1, "R3");
    step(1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, saved, "R8");
    do_issue(1'b0, "R7");
    do_issue(1'b0, "R7");
    do_issue(1'b0, "R7");
    step(1'b0, 1'b1, 4'b0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, "R9");
    do_issue(1'b0, "R9");
    step(1'b0, 1'b1, 4'b1111, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, "R8");
    step(1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R7");
    do_issue(1'b1, "R6");
    do_issue(1'b0, "R5");
    step(1'b1, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R1");
    step(1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R7");
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule